// File: doc/BRIEF.md
# Width-Expanded Dual-Clock FIFO

This block forms one wide first-in, first-out buffer out of several narrower lanes of the same depth placed side by side. Each lane is a complete dual-clock FIFO with its own storage and its own gray-coded pointer crossing. It stores a fixed slice of the combined word. The write clock, read clock, write enable, read enable and reset go to every lane in parallel. The combined input word is split into slices for the lanes, and the lane outputs are concatenated into the combined output word. No lane output drives another lane's output.

The two clocks have no fixed relation, so a lane can see a pointer move one cycle earlier or later than its neighbour. A ready flag may therefore change at different times in different lanes. The block merges the lane flags so that it reports "ready" only after every lane is ready. A reader or writer that obeys the merged flags therefore never splits a word between lanes. In standard mode the active-low empty and full flags are ANDed across the lanes. In first-word fall-through mode the active-low output-ready and input-ready flags are ORed across the lanes. The mode is sampled while reset is asserted and stays fixed until the next reset.

Top module: `wide_fifo`

## Requirements
- R1: Lane k stores bits [k*LANE_W +: LANE_W] of `wdata_i` and drives the same bits of `rdata_o`. Combined words come out whole and in the order they were written.
- R2: In standard mode `rflag_n_o` is an active-low empty flag. It stays 0 until every lane holds a word, and it is 0 out of reset.
- R3: In standard mode `wflag_n_o` is an active-low full flag. It goes to 0 once 2**ADDR_W words are stored and not yet read. A lane never holds more than 2**ADDR_W words.
- R4: In fall-through mode `rflag_n_o` is an active-low output-ready flag. It is 1 out of reset. When a word is written, it appears on `rdata_o` without any read, and `rflag_n_o` goes to 0 only after every lane presents its slice. While no read is issued, the presented word holds.
- R5: In fall-through mode `wflag_n_o` is an active-low input-ready flag. It is 0 out of reset. It goes to 1 once 2**ADDR_W+1 words are held, counting the presented word.
- R6: `fwft_i` chooses the mode (1 means fall-through). The block samples it only while `rst_ni` is low. A change of `fwft_i` after reset has no effect.
- R7: A lane ignores a read while it is empty, and `rdata_o` keeps its last value. A lane ignores a write while it is full, and the word is never stored.
- R8: `half_n_o` comes from lane 0 and is 0 while the write-side occupancy is at least 2**(ADDR_W-1) words. All lanes would report the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset, shared by all lanes |
| fwft_i | input | 1 | Mode select, sampled during reset: 1 for fall-through, 0 for standard |
| wen_i | input | 1 | Write enable |
| wdata_i | input | LANES*LANE_W | Combined write word |
| ren_i | input | 1 | Read enable |
| rdata_o | output | LANES*LANE_W | Combined read word |
| rflag_n_o | output | 1 | Merged empty (standard) or output-ready (fall-through) flag, active low |
| wflag_n_o | output | 1 | Merged full (standard) or input-ready (fall-through) flag, active low |
| half_n_o | output | 1 | Half-full flag from lane 0, active low |

## Verification
The assertions assume that reads and writes are issued only when the merged flags allow them. They also assume that every lane receives the same enables on the same edges, so the lanes keep equal occupancy. The bench drives enables only after it samples the merged flags at the falling edge of the matching clock, and it runs the two clocks at unrelated periods. The one exception is the deliberate out-of-range read or write used to check R7, which relies only on each lane protecting itself.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/ptr_sync.sv
module ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/fifo_lane.sv
module fifo_lane
  import wfifo_pkg::*;
#(
  parameter int W      = 36,
  parameter int ADDR_W = 4
) (
  input  logic       wclk_i,
  input  logic       rclk_i,
  input  logic       rst_ni,
  input  fifo_mode_e wmode_i,
  input  fifo_mode_e rmode_i,
  input  logic       wen_i,
  input  logic [W-1:0] wdata_i,
  input  logic       ren_i,
  output logic [W-1:0] rdata_o,
  output logic       rflag_n_o,
  output logic       wflag_n_o,
  output logic       half_n_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] wgray_s, rgray_s, rbin_s, wcount;
  logic          full, avail, wr_fire, pop, load, valid_q;
  logic [W-1:0]  dout_q;

  ptr_sync #(.W(PW)) u_r2w (.clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray_q), .q_o(rgray_s));
  ptr_sync #(.W(PW)) u_w2r (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray_q), .q_o(wgray_s));

  // write domain
  assign rbin_s  = g2b(rgray_s);
  assign wcount  = wbin_q - rbin_s;
  assign full    = (wcount == PW'(DEPTH));
  assign wr_fire = wen_i && !full;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_fire) begin
      wbin_q  <= wbin_q + 1'b1;
      wgray_q <= b2g(wbin_q + 1'b1);
    end
  end

  always_ff @(posedge wclk_i) begin
    if (wr_fire) mem[wbin_q[ADDR_W-1:0]] <= wdata_i;
  end

  assign wflag_n_o = (wmode_i == MODE_FWFT) ? full : !full;
  assign half_n_o  = !(wcount >= PW'(DEPTH / 2));

  // read domain
  assign avail = (wgray_s != rgray_q);
  assign load  = avail && (!valid_q || ren_i);
  assign pop   = (rmode_i == MODE_FWFT) ? load : (ren_i && avail);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      dout_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (pop) begin
        rbin_q  <= rbin_q + 1'b1;
        rgray_q <= b2g(rbin_q + 1'b1);
        dout_q  <= mem[rbin_q[ADDR_W-1:0]];
      end
      if (rmode_i == MODE_FWFT) begin
        if (load)       valid_q <= 1'b1;
        else if (ren_i) valid_q <= 1'b0;
      end
    end
  end

  assign rdata_o   = dout_q;
  assign rflag_n_o = (rmode_i == MODE_FWFT) ? !valid_q : avail;

  assert_no_overflow_R3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wcount <= PW'(DEPTH));

  assert_gray_step_R2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);

  assert_empty_read_ignored_R7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rmode_i == MODE_STD && ren_i && !avail) |=> ($stable(rdata_o) && $stable(rgray_q)));
endmodule

// File: rtl/flag_merge.sv
module flag_merge
  import wfifo_pkg::*;
#(
  parameter int N = 2
) (
  input  fifo_mode_e   mode_i,
  input  logic [N-1:0] flags_n_i,
  output logic         flag_n_o
);
  // active-low: standard AND, fall-through OR -> "ready" only when all lanes ready
  assign flag_n_o = (mode_i == MODE_FWFT) ? (|flags_n_i) : (&flags_n_i);
endmodule

// File: rtl/wide_fifo.sv
module wide_fifo
  import wfifo_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 36,
  parameter int ADDR_W = 4,
  localparam int DW    = LANES * LANE_W
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          wen_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ren_i,
  output logic [DW-1:0] rdata_o,
  output logic          rflag_n_o,
  output logic          wflag_n_o,
  output logic          half_n_o
);
  fifo_mode_e wmode_q, rmode_q;
  logic [LANES-1:0] rflag_vec, wflag_vec, half_vec;

  // mode follows fwft_i only while reset is held
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) wmode_q <= fifo_mode_e'(fwft_i);
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) rmode_q <= fifo_mode_e'(fwft_i);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fifo_lane #(.W(LANE_W), .ADDR_W(ADDR_W)) u_lane (
      .wclk_i    (wclk_i),
      .rclk_i    (rclk_i),
      .rst_ni    (rst_ni),
      .wmode_i   (wmode_q),
      .rmode_i   (rmode_q),
      .wen_i     (wen_i),
      .wdata_i   (wdata_i[g*LANE_W +: LANE_W]),
      .ren_i     (ren_i),
      .rdata_o   (rdata_o[g*LANE_W +: LANE_W]),
      .rflag_n_o (rflag_vec[g]),
      .wflag_n_o (wflag_vec[g]),
      .half_n_o  (half_vec[g])
    );
  end

  flag_merge #(.N(LANES)) u_rmerge (.mode_i(rmode_q), .flags_n_i(rflag_vec), .flag_n_o(rflag_n_o));
  flag_merge #(.N(LANES)) u_wmerge (.mode_i(wmode_q), .flags_n_i(wflag_vec), .flag_n_o(wflag_n_o));

  assign half_n_o = half_vec[0];

  assert_mode_hold_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $stable(rmode_q));

  assert_fwft_hold_R4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rmode_q == MODE_FWFT && !rflag_n_o && !ren_i) |=> ($stable(rdata_o) && !rflag_n_o));

  assert_half_agree_R8: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    half_vec == {LANES{half_vec[0]}});
endmodule

// File: tb/sim_wide_fifo.sv
module sim_wide_fifo;
  localparam int LANES = 2;
  localparam int LANE_W = 36;
  localparam int ADDR_W = 4;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int DW = LANES * LANE_W;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;

  logic wclk = 0, rclk = 0, rst_n = 0, fwft = 0, wen = 0, ren = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rflag_n, wflag_n, half_n;

  logic [DW-1:0] q[$];
  int checks = 0, errors = 0;
  bit mode_ff = 0;
  bit done = 0;

  always #(WCLK_PERIOD / 2) wclk = ~wclk;
  always #(RCLK_PERIOD / 2) rclk = ~rclk;

  wide_fifo #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .fwft_i(fwft),
    .wen_i(wen), .wdata_i(wdata), .ren_i(ren), .rdata_o(rdata),
    .rflag_n_o(rflag_n), .wflag_n_o(wflag_n), .half_n_o(half_n)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_word();
    return {8'($urandom), 32'($urandom), 32'($urandom)};
  endfunction

  function automatic bit room();
    return mode_ff ? !wflag_n : wflag_n;
  endfunction

  task automatic do_reset(input bit m);
    rst_n = 0; fwft = m; mode_ff = m; wen = 0; ren = 0;
    q.delete();
    repeat (3) @(posedge wclk);
    @(negedge wclk) rst_n = 1;
    repeat (4) @(negedge rclk);
  endtask

  task automatic write_words(input int n, input int gap);
    while (n > 0) begin
      @(negedge wclk);
      if (room() && ($urandom_range(0, 99) >= gap)) begin
        wen = 1; wdata = rnd_word(); q.push_back(wdata); n--;
      end else wen = 0;
    end
    @(negedge wclk) wen = 0;
  endtask

  task automatic fill(output int n);
    n = 0;
    forever begin
      @(negedge wclk);
      if (room()) begin
        wen = 1; wdata = rnd_word(); q.push_back(wdata); n++;
      end else begin
        wen = 0;
        break;
      end
    end
  endtask

  task automatic read_words(input int n, input int gap, output logic [DW-1:0] last);
    bit pend = 0;
    logic [DW-1:0] exp = '0;
    last = '0;
    while (n > 0 || pend) begin
      @(negedge rclk);
      if (!mode_ff) begin
        if (pend) begin
          check(rdata == exp, "R1 std data order", rdata, exp);
          last = rdata;
        end
        pend = 0; ren = 0;
        if (n > 0 && rflag_n && ($urandom_range(0, 99) >= gap)) begin
          ren = 1; pend = 1; exp = q.pop_front(); n--;
        end
      end else begin
        ren = 0;
        if (n > 0 && !rflag_n && ($urandom_range(0, 99) >= gap)) begin
          check(rdata == q[0], "R1 fwft data order", rdata, q[0]);
          last = rdata; ren = 1; void'(q.pop_front()); n--;
        end
      end
    end
    @(negedge rclk) ren = 0;
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", checks, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [DW-1:0] last, probe;

    // ---------------- standard mode ----------------
    do_reset(0);
    check(rflag_n == 1'b0, "R2 empty after reset", DW'(rflag_n), DW'(0));
    check(wflag_n == 1'b1, "R3 not full after reset", DW'(wflag_n), DW'(1));
    check(half_n == 1'b1, "R8 half clear after reset", DW'(half_n), DW'(1));

    fill(n);
    check(n == DEPTH, "R3 words accepted until full", DW'(n), DW'(DEPTH));
    repeat (6) @(negedge rclk);
    check(wflag_n == 1'b0, "R3 full flag", DW'(wflag_n), DW'(0));
    check(half_n == 1'b0, "R8 half flag when full", DW'(half_n), DW'(0));
    check(rflag_n == 1'b1, "R2 not empty", DW'(rflag_n), DW'(1));

    // R7: write while full must be dropped
    @(negedge wclk) begin wen = 1; wdata = {DW{1'b1}}; end
    @(negedge wclk) wen = 0;

    read_words(DEPTH, 0, last);
    repeat (6) @(negedge rclk);
    check(rflag_n == 1'b0, "R2 empty after drain", DW'(rflag_n), DW'(0));
    check(rdata == last, "R7 output after drain", rdata, last);

    // R7: reads while empty ignored
    @(negedge rclk) ren = 1;
    repeat (3) @(negedge rclk);
    ren = 0;
    check(rdata == last, "R7 empty read holds output", rdata, last);
    repeat (6) @(negedge wclk);
    check(half_n == 1'b1, "R8 half clear after drain", DW'(half_n), DW'(1));

    write_words(1, 0);
    repeat (6) @(negedge rclk);
    read_words(1, 0, probe);
    check(probe != {DW{1'b1}}, "R7 full write not stored", probe, ~{DW{1'b1}});

    fork
      write_words(300, 30);
      read_words(300, 40, last);
    join
    check(q.size() == 0, "R1 std stream complete", DW'(q.size()), DW'(0));

    // ---------------- fall-through mode ----------------
    do_reset(1);
    check(wflag_n == 1'b0, "R5 input ready after reset", DW'(wflag_n), DW'(0));
    check(rflag_n == 1'b1, "R4 output not ready after reset", DW'(rflag_n), DW'(1));

    fwft = 0; // R6: ignored after reset
    write_words(1, 0);
    repeat (6) @(negedge rclk);
    check(rflag_n == 1'b0, "R4 R6 word falls through", DW'(rflag_n), DW'(0));
    check(rdata == q[0], "R4 first word without read", rdata, q[0]);

    fill(n);
    check(n == DEPTH, "R5 accepted beyond presented word", DW'(n), DW'(DEPTH));
    repeat (6) @(negedge rclk);
    check(wflag_n == 1'b1, "R5 input not ready when full", DW'(wflag_n), DW'(1));
    check(rdata == q[0], "R4 head holds without read", rdata, q[0]);

    read_words(DEPTH + 1, 0, last);
    repeat (6) @(negedge rclk);
    check(rflag_n == 1'b1, "R4 not ready after drain", DW'(rflag_n), DW'(1));

    fork
      write_words(300, 40);
      read_words(300, 30, last);
    join
    check(q.size() == 0, "R1 fwft stream complete", DW'(q.size()), DW'(0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule